// File: doc/BRIEF.md
# Barrier-Aware L1 Allocation Controller

This block sits next to the L1 data cache of a GPU core. It decides, for every lookup, whether a missing line is filled into the cache and which way of the indexed set it replaces. Each request carries a criticality tag from outside logic. Warps that are still far from the barrier their thread block waits on are tagged critical. All other warps are tagged non-critical.

Critical misses always fill. Non-critical misses are handled by one of two run-time modes. In the greedy mode, a non-critical miss never fills and is served as a bypass. In the friendly mode, a non-critical miss may fill, but only into an invalid way or a way whose line was filled by a non-critical warp. The block watches how often non-critical accesses hit in the L1 and picks the mode window by window.

The block keeps a small amount of state. Each way holds one priority bit, and each set holds an LRU age per way. Two counters measure the hit rate. Tag and data arrays, and the warp scheduler, stay outside the block. The decision is registered and appears one clock after the request.

Top module: `bacm_alloc_ctrl`

## Requirements
- R1: In greedy mode (`mode_friendly`=0), a non-critical miss gives `dec_alloc`=0 and `dec_way`=0.
- R2: A critical miss always gives `dec_alloc`=1, whatever the mode.
- R3: In friendly mode, a non-critical miss may only take a way that is invalid (`line_valid` bit = 0) or whose priority bit is 0. If no such way exists, it gives `dec_alloc`=0 and `dec_way`=0.
- R4: Among the eligible ways, the lowest-index invalid way is chosen first. If no eligible way is invalid, the eligible way least recently used in that set is chosen.
- R5: A critical fill sets the filled way's priority bit, and a non-critical fill clears it. A hit from a critical warp sets the hit way's priority bit. Any other hit leaves the bit unchanged.
- R6: A hit gives `dec_alloc`=0 and `dec_way`=0, and it makes the hit way the most recently used way. A fill makes the filled way the most recently used way. A bypass leaves the LRU order and the priority bits unchanged.
- R7: Non-critical requests are counted, together with how many of them hit; critical requests are not counted. When the count reaches WINDOW (1024), the mode becomes friendly if 4×hits ≥ count, and greedy otherwise. Both counters then clear. The new mode first applies to the next request, and `mode_friendly` shows it one clock after the window's last request.
- R8: After reset, the mode is friendly, all priority bits are 0, `dec_valid` is 0, and in every set way 0 is most recently used, with the order rising with the index so that the highest way is least recently used.
- R9: For a request at clock edge N, `dec_valid` and `dec_warp` (an echo of `req_warp`), together with `dec_alloc` and `dec_way`, are valid after edge N. Without a request, `dec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A lookup result is presented |
| req_warp | input | WARP_W | Requesting warp ID |
| req_crit | input | 1 | 1 = critical warp |
| req_set | input | SET_W | Set index of the access |
| req_hit | input | 1 | 1 = the lookup hit |
| req_hit_way | input | WAY_W | Way that hit (when req_hit) |
| line_valid | input | NUM_WAYS | Valid bits of the indexed set's ways |
| dec_valid | output | 1 | Decision present |
| dec_warp | output | WARP_W | Warp ID of the decision |
| dec_alloc | output | 1 | 1 = fill the line into dec_way |
| dec_way | output | WAY_W | Victim way (0 when not filling) |
| mode_friendly | output | 1 | 1 = friendly mode, 0 = greedy mode |

## Verification
Every decision output is due one clock after its request. The mode flag changes one clock after the request that closes a window, and that request is still decided under the old mode. The bench drives each request on a falling edge and keeps the values its model expects for that request. It compares them at the next falling edge, by which time exactly one rising edge has registered the result. Windows of exactly 256 and 255 hits out of 1024 cover both sides of the 25% threshold.

// File: rtl/bacm_pkg.sv
package bacm_pkg;
  typedef enum logic {
    MODE_GREEDY   = 1'b0,
    MODE_FRIENDLY = 1'b1
  } bacm_mode_e;
endpackage

// File: rtl/bacm_set_state.sv
// Per-set priority bits and LRU ages; one read/update port indexed by the current request.
module bacm_set_state #(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int AGE_W = WAY_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [SET_W-1:0]          set_idx,
  input  logic                      upd_en,
  input  logic [WAY_W-1:0]          upd_way,
  input  logic                      prio_wr,
  input  logic                      prio_val,
  output logic [NUM_WAYS-1:0]       prio_o,
  output logic [NUM_WAYS*AGE_W-1:0] age_o
);
  logic [NUM_WAYS-1:0]       prio_mem [NUM_SETS];
  logic [NUM_WAYS*AGE_W-1:0] age_mem  [NUM_SETS];
  logic [NUM_WAYS*AGE_W-1:0] age_next;
  logic [AGE_W-1:0]          touched_age;

  assign prio_o = prio_mem[set_idx];
  assign age_o  = age_mem[set_idx];

  always_comb begin
    touched_age = age_o[upd_way*AGE_W +: AGE_W];
    age_next    = age_o;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (WAY_W'(i) == upd_way)
        age_next[i*AGE_W +: AGE_W] = '0;
      else if (age_o[i*AGE_W +: AGE_W] < touched_age)
        age_next[i*AGE_W +: AGE_W] = age_o[i*AGE_W +: AGE_W] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        prio_mem[s] <= '0;
        for (int i = 0; i < NUM_WAYS; i++)
          age_mem[s][i*AGE_W +: AGE_W] <= AGE_W'(i);
      end
    end else if (upd_en) begin
      age_mem[set_idx] <= age_next;
      if (prio_wr)
        prio_mem[set_idx][upd_way] <= prio_val;
    end
  end
endmodule

// File: rtl/bacm_victim_sel.sv
// Combinational eligibility filter and victim pick.
module bacm_victim_sel #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int AGE_W = WAY_W
) (
  input  logic                      crit,
  input  logic                      friendly,
  input  logic [NUM_WAYS-1:0]       valid,
  input  logic [NUM_WAYS-1:0]       prio,
  input  logic [NUM_WAYS*AGE_W-1:0] age,
  output logic                      can_alloc,
  output logic [WAY_W-1:0]          way
);
  logic [NUM_WAYS-1:0] elig;
  logic [NUM_WAYS-1:0] free;
  logic                found_free;
  logic                have_old;
  logic [AGE_W-1:0]    best_age;

  always_comb begin
    for (int i = 0; i < NUM_WAYS; i++)
      elig[i] = crit | (friendly & (~valid[i] | ~prio[i]));
    free       = elig & ~valid;
    can_alloc  = |elig;
    way        = '0;
    found_free = 1'b0;
    have_old   = 1'b0;
    best_age   = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (!found_free && free[i]) begin
        way        = WAY_W'(i);
        found_free = 1'b1;
      end
    end
    if (!found_free) begin
      for (int i = 0; i < NUM_WAYS; i++) begin
        if (elig[i] && (!have_old || age[i*AGE_W +: AGE_W] > best_age)) begin
          way      = WAY_W'(i);
          best_age = age[i*AGE_W +: AGE_W];
          have_old = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bacm_mode_ctrl.sv
// Windowed hit-rate monitor for non-critical accesses; selects greedy or friendly.
module bacm_mode_ctrl
  import bacm_pkg::*;
#(
  parameter int WINDOW = 1024,
  parameter int CNT_W  = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       acc_en,
  input  logic       acc_hit,
  output bacm_mode_e mode
);
  localparam logic [CNT_W-1:0] WIN_C = CNT_W'(WINDOW);

  logic [CNT_W-1:0] acc_q, hit_q, acc_nxt, hit_nxt;
  logic             rate_ok;

  always_comb begin
    acc_nxt = acc_q + CNT_W'(acc_q != '1);
    hit_nxt = hit_q + CNT_W'(acc_hit && hit_q != '1);
    rate_ok = {hit_nxt, 2'b00} >= {2'b00, acc_nxt};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      hit_q <= '0;
      mode  <= MODE_FRIENDLY;
    end else if (acc_en) begin
      if (acc_nxt >= WIN_C) begin
        mode  <= rate_ok ? MODE_FRIENDLY : MODE_GREEDY;
        acc_q <= '0;
        hit_q <= '0;
      end else begin
        acc_q <= acc_nxt;
        hit_q <= hit_nxt;
      end
    end
  end
endmodule

// File: rtl/bacm_alloc_ctrl.sv
module bacm_alloc_ctrl
  import bacm_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  parameter int WARP_W   = 6,
  parameter int WINDOW   = 1024,
  parameter int CNT_W    = 16,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int AGE_W   = WAY_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [WARP_W-1:0]   req_warp,
  input  logic                req_crit,
  input  logic [SET_W-1:0]    req_set,
  input  logic                req_hit,
  input  logic [WAY_W-1:0]    req_hit_way,
  input  logic [NUM_WAYS-1:0] line_valid,
  output logic                dec_valid,
  output logic [WARP_W-1:0]   dec_warp,
  output logic                dec_alloc,
  output logic [WAY_W-1:0]    dec_way,
  output logic                mode_friendly
);
  bacm_mode_e                mode;
  logic [NUM_WAYS-1:0]       set_prio;
  logic [NUM_WAYS*AGE_W-1:0] set_age;
  logic                      can_alloc;
  logic [WAY_W-1:0]          victim;
  logic                      fill;
  logic                      upd_en;
  logic [WAY_W-1:0]          upd_way;
  logic                      prio_wr;

  bacm_mode_ctrl #(.WINDOW(WINDOW), .CNT_W(CNT_W)) u_mode (
    .clk     (clk),
    .rst     (rst),
    .acc_en  (req_valid && !req_crit),
    .acc_hit (req_hit),
    .mode    (mode)
  );

  bacm_victim_sel #(.NUM_WAYS(NUM_WAYS)) u_pick (
    .crit      (req_crit),
    .friendly  (mode == MODE_FRIENDLY),
    .valid     (line_valid),
    .prio      (set_prio),
    .age       (set_age),
    .can_alloc (can_alloc),
    .way       (victim)
  );

  always_comb begin
    fill    = req_valid && !req_hit && can_alloc;
    upd_en  = fill || (req_valid && req_hit);
    upd_way = req_hit ? req_hit_way : victim;
    prio_wr = fill || (req_hit && req_crit);
  end

  bacm_set_state #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_state (
    .clk      (clk),
    .rst      (rst),
    .set_idx  (req_set),
    .upd_en   (upd_en),
    .upd_way  (upd_way),
    .prio_wr  (prio_wr),
    .prio_val (req_crit),
    .prio_o   (set_prio),
    .age_o    (set_age)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_warp  <= '0;
      dec_alloc <= 1'b0;
      dec_way   <= '0;
    end else begin
      dec_valid <= req_valid;
      dec_warp  <= req_valid ? req_warp : '0;
      dec_alloc <= fill;
      dec_way   <= fill ? victim : '0;
    end
  end

  assign mode_friendly = (mode == MODE_FRIENDLY);
endmodule

// File: rtl/bacm_alloc_chk.sv
module bacm_alloc_chk #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic                req_crit,
  input logic                req_hit,
  input logic [NUM_WAYS-1:0] line_valid,
  input logic                dec_valid,
  input logic                dec_alloc,
  input logic [WAY_W-1:0]    dec_way,
  input logic                mode_friendly
);
  // R1
  greedy_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_crit && !req_hit && !mode_friendly |=> !dec_alloc && dec_way == '0);

  // R2
  crit_fill_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_crit && !req_hit |=> dec_alloc);

  // R4
  free_way_first_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_hit && (req_crit || mode_friendly) && !(&line_valid)
    |=> dec_alloc && !(($past(line_valid) >> dec_way) & NUM_WAYS'(1)));

  // R6
  hit_no_fill_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_hit |=> !dec_alloc && dec_way == '0);

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_crit) |=> $stable(mode_friendly));

  // R9
  dec_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> dec_valid == $past(req_valid));

  // R9
  idle_no_fill_chk: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> !dec_alloc);
endmodule

bind bacm_alloc_ctrl bacm_alloc_chk #(.NUM_WAYS(NUM_WAYS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_crit      (req_crit),
  .req_hit       (req_hit),
  .line_valid    (line_valid),
  .dec_valid     (dec_valid),
  .dec_alloc     (dec_alloc),
  .dec_way       (dec_way),
  .mode_friendly (mode_friendly)
);

// File: tb/bacm_alloc_ctrl_tb.sv
module bacm_alloc_ctrl_tb;
  localparam int NW  = 4;
  localparam int NS  = 16;
  localparam int WW  = 6;
  localparam int WIN = 1024;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [WW-1:0] req_warp = '0;
  logic          req_crit = 1'b0;
  logic [3:0]    req_set = '0;
  logic          req_hit = 1'b0;
  logic [1:0]    req_hit_way = '0;
  logic [NW-1:0] line_valid = '0;
  logic          dec_valid, dec_alloc, mode_friendly;
  logic [WW-1:0] dec_warp;
  logic [1:0]    dec_way;

  always #10 clk = ~clk;

  bacm_alloc_ctrl #(.NUM_WAYS(NW), .NUM_SETS(NS), .WARP_W(WW), .WINDOW(WIN)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_warp(req_warp),
    .req_crit(req_crit), .req_set(req_set), .req_hit(req_hit),
    .req_hit_way(req_hit_way), .line_valid(line_valid), .dec_valid(dec_valid),
    .dec_warp(dec_warp), .dec_alloc(dec_alloc), .dec_way(dec_way),
    .mode_friendly(mode_friendly));

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  // reference state
  int  lru_q [NS][$];
  bit  prio_m [NS][NW];
  bit  m_friendly;
  int  m_acc, m_hits;
  // expectation for the outstanding request
  bit    e_valid, e_alloc, e_mode;
  int    e_way, e_warp;
  string e_tag;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic touch(int s, int w);
    for (int k = 0; k < lru_q[s].size(); k++)
      if (lru_q[s][k] == w) begin
        lru_q[s].delete(k);
        break;
      end
    lru_q[s].push_front(w);
  endtask

  task automatic model_reset();
    for (int s = 0; s < NS; s++) begin
      lru_q[s].delete();
      for (int w = 0; w < NW; w++) begin
        lru_q[s].push_back(w);
        prio_m[s][w] = 0;
      end
    end
    m_friendly = 1;
    m_acc = 0;
    m_hits = 0;
  endtask

  // Compare the outstanding expectation, then issue one request (or idle).
  task automatic step(bit v, bit crit, int s, bit hit, int hw, logic [NW-1:0] lv, int warp);
    bit elig [NW];
    bit any;
    @(negedge clk);
    chk("R9 dec_valid", dec_valid, e_valid);
    chk("R9 dec_warp", dec_warp, e_warp);
    chk({e_tag, " dec_alloc"}, dec_alloc, e_alloc);
    chk({e_tag, " R4 dec_way"}, dec_way, e_way);
    chk("R7 mode", mode_friendly, e_mode);
    e_valid = v;
    e_warp  = v ? warp : 0;
    e_alloc = 0;
    e_way   = 0;
    e_tag   = "R9";
    if (v) begin
      if (hit) begin
        e_tag = "R6";
        touch(s, hw);
        if (crit) prio_m[s][hw] = 1;
      end else begin
        e_tag = crit ? "R2" : (m_friendly ? "R3/R5" : "R1");
        any = 0;
        for (int w = 0; w < NW; w++) begin
          elig[w] = crit || (m_friendly && (!lv[w] || !prio_m[s][w]));
          if (elig[w]) any = 1;
        end
        if (any) begin
          e_alloc = 1;
          e_way = -1;
          for (int w = 0; w < NW; w++)
            if (e_way < 0 && elig[w] && !lv[w]) e_way = w;
          if (e_way < 0)
            for (int k = NW - 1; k >= 0; k--)
              if (e_way < 0 && elig[lru_q[s][k]]) e_way = lru_q[s][k];
          prio_m[s][e_way] = crit;
          touch(s, e_way);
        end
      end
      if (!crit) begin
        m_acc++;
        if (hit) m_hits++;
        if (m_acc == WIN) begin
          m_friendly = (m_hits * 4 >= m_acc);
          m_acc = 0;
          m_hits = 0;
        end
      end
    end
    e_mode = m_friendly;
    req_valid   = v;
    req_crit    = crit;
    req_set     = 4'(s);
    req_hit     = hit;
    req_hit_way = 2'(hw);
    line_valid  = lv;
    req_warp    = WW'(warp);
  endtask

  function automatic logic [NW-1:0] rand_lv();
    return ($urandom_range(0, 3) == 0) ? NW'($urandom) : '1;
  endfunction

  // One full window of non-critical requests with n_hits hits, critical traffic mixed in.
  task automatic run_window(int n_hits);
    for (int k = 0; k < WIN; k++) begin
      step(1, 0, $urandom_range(0, NS-1), k < n_hits, $urandom_range(0, NW-1),
           rand_lv(), $urandom_range(0, 63));
      if (k % 3 == 0)
        step(1, 1, $urandom_range(0, NS-1), $urandom_range(0, 1), $urandom_range(0, NW-1),
             rand_lv(), $urandom_range(0, 63));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    e_valid = 0; e_alloc = 0; e_way = 0; e_warp = 0; e_mode = 1; e_tag = "R8";
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R8: reset state
    chk("R8 dec_valid", dec_valid, 0);
    chk("R8 mode", mode_friendly, 1);
    // R8/R4: all valid, critical miss picks highest way as LRU
    step(1, 1, 0, 0, 0, '1, 5);
    step(0, 0, 0, 0, 0, '0, 0);
    // R4: lowest invalid way first (ways 1 and 3 invalid -> 1)
    step(1, 1, 1, 0, 0, 4'b0101, 6);
    // R5: critical fill on set 2 way 3, then friendly non-critical miss avoids it
    step(1, 1, 2, 0, 0, '1, 7);
    step(1, 0, 2, 0, 0, '1, 8);
    // R5: mark every way critical in set 3, non-critical miss must bypass (R3)
    for (int w = 0; w < NW; w++) step(1, 1, 3, 1, w, '1, 9);
    step(1, 0, 3, 0, 0, '1, 10);
    // R6: hit moves way to MRU, then critical miss victim follows
    step(1, 0, 4, 1, 3, '1, 11);
    step(1, 1, 4, 0, 0, '1, 12);
    // R7: windows on both sides of the 25% threshold
    run_window(100);  // greedy
    run_window(256);  // exactly 25% -> friendly
    run_window(255);  // just below -> greedy
    // R1: greedy mode bypass traffic
    for (int k = 0; k < 50; k++)
      step(1, 0, $urandom_range(0, NS-1), 0, 0, rand_lv(), k);
    run_window(600);  // friendly
    // mixed random traffic with idles
    for (int k = 0; k < 3000; k++)
      step($urandom_range(0, 4) != 0, $urandom_range(0, 1), $urandom_range(0, NS-1),
           $urandom_range(0, 2) == 0, $urandom_range(0, NW-1), rand_lv(), $urandom_range(0, 63));
    step(0, 0, 0, 0, 0, '0, 0);
    step(0, 0, 0, 0, 0, '0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule